// File: doc/BRIEF.md
# IDE Bus-Master Channel Control and Interrupt Status Register

This block holds the per-channel control and status state of a host-to-IDE bus-master controller. The controller moves data either by true DMA or by virtual DMA, in which the device side runs PIO while the host side runs DMA. Software writes a command byte whose bit 0 starts bus-master operation. It reads DMA status bits and a virtual-DMA-complete cause bit. It also reads a device-interrupt-pending bit that follows the device interrupt line. It clears the status bits by writing ones.

The DMA and PIO engines report events to the block as single-cycle pulses. The device interrupt line arrives already synchronised to the clock. The block drives a level host interrupt. While bus-master operation is running, it closes access to the task-file status. Register reads are combinational on the address. Side effects of a read take place on the clock edge where the read strobe is high.

Top module: `ide_chan_csr`

## Requirements
- R1: After reset the command byte, the active, error and interrupt bits, the virtual-DMA flag and the device-pending flag are all 0; host_irq is 0 and tf_open is 1.
- R2: A write to address 0 stores reg_wdata[7:0] as the command byte, which reads back at reg_rdata[7:0] of address 0.
- R3: Active status (address 0 bit 16) becomes 1 on the edge where a write sets bit 0 while bit 0 was 0. A dma_done pulse clears it, unless that same edge also starts the channel.
- R4: A write with bit 0 equal to 0 (for example 00h) clears the active bit on that edge, whatever else happens in that cycle.
- R5: While command bit 0 is 1, tf_open is 0, a read of address 2 returns 0, and that read does not clear the device-pending flag. With bit 0 clear, address 2 returns dev_status in bits [7:0].
- R6: A dma_err pulse sets the error bit (address 0 bit 17). A dma_done pulse sets the interrupt bit (address 0 bit 18). Each bit is cleared only by writing 1 to its own position; writing 0 there has no effect.
- R7: A vdma_done pulse sets the virtual-DMA flag (address 1 bit 10) and the interrupt bit. Writing 1 to either bit 17 or bit 18 of address 0 clears the flag.
- R8: host_irq is 1 exactly when the interrupt bit or the virtual-DMA flag is set, and holds until software clears both.
- R9: A rising edge on dev_intrq sets the device-pending flag (address 1 bit 11) and the interrupt bit. A permitted read of address 2 clears the flag. A level held high does not set it again.
- R10: Write-one-to-clear of bits 17 and 18 leaves the device-pending flag unchanged.
- R11: When a set event and a clear of the same bit arrive on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | 0 bus-master, 1 channel status, 2 task-file status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| dma_done | input | 1 | DMA engine transfer-finished pulse |
| dma_err | input | 1 | DMA engine error pulse |
| vdma_done | input | 1 | Virtual DMA transfer-complete pulse |
| dev_intrq | input | 1 | Device interrupt line, synchronised |
| dev_status | input | 8 | Device status byte from the task file |
| host_irq | output | 1 | Level host interrupt |
| tf_open | output | 1 | Task-file access permitted |

## Verification
The bench targets races on a single edge. One case clears the interrupt bit while dma_done sets it; a design in which clear wins would drop a completion. Another case re-reads the device-pending flag after a combined bit 17/18 clear. A design that wired that clear to the pending flag would lose a device interrupt that races with virtual-DMA completion. The bench also tries a task-file read while the channel runs, which must neither return data nor consume the pending flag. It checks that stopping the channel drops the active bit at once, and that a dev_intrq level held high is not counted twice.

// File: rtl/ide_csr_pkg.sv
package ide_csr_pkg;
  localparam int ADDR_W     = 2;
  localparam int DATA_W     = 32;
  localparam int CMD_W      = 8;
  localparam int TF_W       = 8;
  localparam int BM_START   = 0;
  localparam int BM_ACTIVE  = 16;
  localparam int BM_ERR     = 17;
  localparam int BM_IRQ     = 18;
  localparam int CS_VDMA    = 10;
  localparam int CS_DEVPEND = 11;

  localparam logic [ADDR_W-1:0] A_BM = 2'd0;
  localparam logic [ADDR_W-1:0] A_CS = 2'd1;
  localparam logic [ADDR_W-1:0] A_TF = 2'd2;

  // sticky bit: a set event always beats a clear on the same edge
  function automatic logic sticky_next(logic cur, logic set_ev, logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

  // active bit: stop beats start beats done
  function automatic logic active_next(logic cur, logic run_now, logic wr,
                                       logic wr_run, logic done);
    logic n;
    n = cur;
    if (wr && !wr_run)             n = 1'b0;
    else if (wr && wr_run && !run_now) n = 1'b1;
    else if (done)                 n = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/ide_bm_cmd.sv
module ide_bm_cmd
  import ide_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             dma_done,
  output logic [CMD_W-1:0] cmd_q,
  output logic             active_q
);
  logic run_now;
  logic evt_start;
  logic evt_stop;
  logic active_d;

  assign run_now   = cmd_q[BM_START];
  assign evt_start = cmd_wr &  cmd_wdata[BM_START] & ~run_now;
  assign evt_stop  = cmd_wr & ~cmd_wdata[BM_START];
  assign active_d  = active_next(active_q, run_now, cmd_wr, cmd_wdata[BM_START], dma_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_wdata;
      active_q <= active_d;
    end
  end

  a_r3_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> active_q);
  a_r4_stop_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !active_q);
  a_r3_active_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cmd_q[BM_START]);
  a_r2_cmd_written: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q == $past(cmd_wdata));
endmodule

// File: rtl/ide_bm_status.sv
module ide_bm_status
  import ide_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_err,
  input  logic clr_irq,
  input  logic dma_done,
  input  logic dma_err,
  input  logic vdma_done,
  input  logic dev_intrq,
  input  logic tf_rd_ok,
  output logic err_q,
  output logic irq_q,
  output logic vdma_q,
  output logic devpend_q
);
  logic intrq_prev;
  logic evt_dev_rise;
  logic evt_irq_set;
  logic evt_vdma_clr;

  assign evt_dev_rise = dev_intrq & ~intrq_prev;
  assign evt_irq_set  = dma_done | vdma_done | evt_dev_rise;
  assign evt_vdma_clr = clr_err | clr_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intrq_prev <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      vdma_q     <= 1'b0;
      devpend_q  <= 1'b0;
    end else begin
      intrq_prev <= dev_intrq;
      err_q      <= sticky_next(err_q, dma_err, clr_err);
      irq_q      <= sticky_next(irq_q, evt_irq_set, clr_irq);
      vdma_q     <= sticky_next(vdma_q, vdma_done, evt_vdma_clr);
      devpend_q  <= sticky_next(devpend_q, evt_dev_rise, tf_rd_ok);
    end
  end

  a_r11_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq_set |=> irq_q);
  a_r11_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err |=> err_q);
  a_r9_rise_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dev_rise |=> devpend_q);
  a_r6_err_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err && !dma_err |=> !err_q);
  a_r10_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    devpend_q && evt_vdma_clr && !tf_rd_ok |=> devpend_q);
  a_r7_vdma_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vdma_clr && !vdma_done |=> !vdma_q);
endmodule

// File: rtl/ide_tf_gate.sv
module ide_tf_gate
  import ide_csr_pkg::*;
(
  input  logic            run_now,
  input  logic            rd_tf,
  input  logic [TF_W-1:0] dev_status,
  output logic            tf_open,
  output logic            tf_rd_ok,
  output logic [TF_W-1:0] tf_rdata
);
  assign tf_open  = ~run_now;
  assign tf_rd_ok = rd_tf & tf_open;
  assign tf_rdata = tf_open ? dev_status : '0;
endmodule

// File: rtl/ide_chan_csr.sv
module ide_chan_csr
  import ide_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_done,
  input  logic              dma_err,
  input  logic              vdma_done,
  input  logic              dev_intrq,
  input  logic [TF_W-1:0]   dev_status,
  output logic              host_irq,
  output logic              tf_open
);
  logic             wr_bm;
  logic             rd_tf;
  logic             clr_err;
  logic             clr_irq;
  logic [CMD_W-1:0] cmd_q;
  logic             active_q;
  logic             err_q;
  logic             irq_q;
  logic             vdma_q;
  logic             devpend_q;
  logic             tf_rd_ok;
  logic [TF_W-1:0]  tf_rdata;

  assign wr_bm   = reg_wr & (reg_addr == A_BM);
  assign rd_tf   = reg_rd & (reg_addr == A_TF);
  assign clr_err = wr_bm & reg_wdata[BM_ERR];
  assign clr_irq = wr_bm & reg_wdata[BM_IRQ];

  ide_bm_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (wr_bm),
    .cmd_wdata(reg_wdata[CMD_W-1:0]),
    .dma_done (dma_done),
    .cmd_q    (cmd_q),
    .active_q (active_q)
  );

  ide_tf_gate u_gate (
    .run_now   (cmd_q[BM_START]),
    .rd_tf     (rd_tf),
    .dev_status(dev_status),
    .tf_open   (tf_open),
    .tf_rd_ok  (tf_rd_ok),
    .tf_rdata  (tf_rdata)
  );

  ide_bm_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_err  (clr_err),
    .clr_irq  (clr_irq),
    .dma_done (dma_done),
    .dma_err  (dma_err),
    .vdma_done(vdma_done),
    .dev_intrq(dev_intrq),
    .tf_rd_ok (tf_rd_ok),
    .err_q    (err_q),
    .irq_q    (irq_q),
    .vdma_q   (vdma_q),
    .devpend_q(devpend_q)
  );

  assign host_irq = irq_q | vdma_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_BM: begin
        reg_rdata[CMD_W-1:0] = cmd_q;
        reg_rdata[BM_ACTIVE] = active_q;
        reg_rdata[BM_ERR]    = err_q;
        reg_rdata[BM_IRQ]    = irq_q;
      end
      A_CS: begin
        reg_rdata[CS_VDMA]    = vdma_q;
        reg_rdata[CS_DEVPEND] = devpend_q;
      end
      A_TF:    reg_rdata[TF_W-1:0] = tf_rdata;
      default: reg_rdata = '0;
    endcase
  end

  a_r5_blocked_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
    devpend_q && rd_tf && cmd_q[BM_START] |=> devpend_q);
  a_r5_blocked_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[BM_START] && reg_addr == A_TF |-> reg_rdata == '0);
  a_r8_vdma_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    vdma_done |=> host_irq);
  a_r9_read_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rd_ok && !(dev_intrq && !$past(dev_intrq)) |=> !devpend_q);
endmodule

// File: tb/ide_chan_csr_test.sv
module ide_chan_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_done = 1'b0, dma_err = 1'b0, vdma_done = 1'b0, dev_intrq = 1'b0;
  logic [7:0]  dev_status = 8'h5A;
  logic        host_irq, tf_open;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cmd = 0;
  bit m_act = 0, m_err = 0, m_irq = 0, m_vd = 0, m_pend = 0, m_prev = 0;

  always #4 clk = ~clk;

  ide_chan_csr uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference updated on every edge
  always @(posedge clk) begin
    bit wbm, c17, c18, rise, tfr, n_act;
    if (!rst_n) begin
      m_cmd = 0; m_act = 0; m_err = 0; m_irq = 0; m_vd = 0; m_pend = 0; m_prev = 0;
    end else begin
      wbm  = reg_wr && reg_addr == 2'd0;
      c17  = wbm && reg_wdata[17];
      c18  = wbm && reg_wdata[18];
      rise = dev_intrq && !m_prev;
      tfr  = reg_rd && reg_addr == 2'd2 && !m_cmd[0];
      n_act = m_act;
      if (wbm && reg_wdata[0] == 1'b0) n_act = 0;
      else if (wbm && !m_cmd[0]) n_act = 1;
      else if (dma_done) n_act = 0;
      m_act = n_act;
      if (wbm) m_cmd = reg_wdata[7:0];
      if (dma_err) m_err = 1; else if (c17) m_err = 0;
      if (dma_done || vdma_done || rise) m_irq = 1; else if (c18) m_irq = 0;
      if (vdma_done) m_vd = 1; else if (c17 || c18) m_vd = 0;
      if (rise) m_pend = 1; else if (tfr) m_pend = 0;
      m_prev = dev_intrq;
    end
    #2;
    if (rst_n) begin
      chk(host_irq == (m_irq | m_vd), "R8 host_irq", host_irq, m_irq | m_vd);
      chk(tf_open == !m_cmd[0], "R5 tf_open", tf_open, !m_cmd[0]);
      case (reg_addr)
        2'd0: begin
          chk(reg_rdata[7:0] == m_cmd, "R2 cmd", reg_rdata[7:0], m_cmd);
          chk(reg_rdata[16] == m_act, "R3 active", reg_rdata[16], m_act);
          chk(reg_rdata[17] == m_err, "R6 err", reg_rdata[17], m_err);
          chk(reg_rdata[18] == m_irq, "R6 irq", reg_rdata[18], m_irq);
        end
        2'd1: begin
          chk(reg_rdata[10] == m_vd, "R7 vdma", reg_rdata[10], m_vd);
          chk(reg_rdata[11] == m_pend, "R9 pend", reg_rdata[11], m_pend);
        end
        2'd2: chk(reg_rdata == (m_cmd[0] ? 32'd0 : {24'd0, dev_status}), "R5 tf data",
                  reg_rdata, m_cmd[0] ? 32'd0 : {24'd0, dev_status});
        default: chk(reg_rdata == 0, "R2 unused addr", reg_rdata, 0);
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(2'd0, v); chk(v == 0, "R1 bm reset", v, 0);
    peek(2'd1, v); chk(v == 0, "R1 status reset", v, 0);
    chk(host_irq == 0, "R1 host_irq", host_irq, 0);
    chk(tf_open == 1, "R1 tf_open", tf_open, 1);
    // R2 R3 start
    wr(2'd0, 32'h05);
    peek(2'd0, v); chk(v == 32'h0001_0005, "R2 R3 start", v, 32'h0001_0005);
    chk(tf_open == 0, "R5 blocked", tf_open, 0);
    // R5 blocked read keeps pending
    @(negedge clk); dev_intrq = 1;
    rd(2'd2);
    peek(2'd1, v); chk(v[11] == 1, "R5 pend kept while blocked", v[11], 1);
    peek(2'd2, v); chk(v == 0, "R5 blocked data", v, 0);
    // R4 stop with 00h
    wr(2'd0, 32'h00);
    peek(2'd0, v); chk(v[16] == 0, "R4 stop clears active", v[16], 0);
    // R6 error w1c per bit
    @(negedge clk); dma_err = 1; @(negedge clk); dma_err = 0;
    wr(2'd0, 32'h0004_0000);
    peek(2'd0, v); chk(v[17] == 1, "R6 err kept on bit18 clear", v[17], 1);
    wr(2'd0, 32'h0002_0000);
    peek(2'd0, v); chk(v[17] == 0, "R6 err cleared", v[17], 0);
    // R7 R8 vdma then clear, R10 pend unaffected
    @(negedge clk); vdma_done = 1; @(negedge clk); vdma_done = 0;
    peek(2'd1, v); chk(v[10] == 1, "R7 vdma set", v[10], 1);
    chk(host_irq == 1, "R8 irq high", host_irq, 1);
    wr(2'd0, 32'h0006_0000);
    peek(2'd1, v); chk(v[10] == 0, "R7 vdma cleared", v[10], 0);
    chk(v[11] == 1, "R10 pend survives w1c", v[11], 1);
    chk(host_irq == 0, "R8 irq low", host_irq, 0);
    // R9 read clears, held level does not re-set
    rd(2'd2);
    peek(2'd1, v); chk(v[11] == 0, "R9 read clears pend", v[11], 0);
    repeat (3) @(negedge clk);
    peek(2'd1, v); chk(v[11] == 0, "R9 level no re-set", v[11], 0);
    // R11 set wins
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0004_0000; dma_done = 1;
    @(negedge clk); reg_wr = 0; reg_wdata = 0; dma_done = 0;
    peek(2'd0, v); chk(v[18] == 1, "R11 set beats clear", v[18], 1);
    wr(2'd0, 32'h0006_0000);
    // random traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_addr   = 2'($urandom % 4);
      reg_wr     = ($urandom % 4) == 0;
      reg_rd     = ($urandom % 3) == 0;
      reg_wdata  = $urandom;
      if ($urandom % 2) reg_wdata[0] = 0;
      dma_done   = ($urandom % 8) == 0;
      dma_err    = ($urandom % 12) == 0;
      vdma_done  = ($urandom % 10) == 0;
      if (($urandom % 6) == 0) dev_intrq = ~dev_intrq;
      dev_status = 8'($urandom);
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; dma_done = 0; dma_err = 0; vdma_done = 0;
    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end
endmodule